// File: doc/BRIEF.md
# BCD Time-and-Calendar Register Bank

This block keeps wall-clock time and a calendar as a chain of 4-bit BCD registers. The chain runs from tenths of a second up through the month, and also holds a day-of-week counter and a four-state leap-year phase. An external one-cycle advance pulse arrives ten times a second and moves the chain on by 0.1 s, but only while the run latch is set. Hours count 00 to 23. Each month closes after 28, 29, 30 or 31 days, depending on the month and on whether the phase register marks the current year as a leap year.

A host reaches every register through a nibble-wide port. The port has a 4-bit register address, an active-low chip select, active-low read and write strobes, a write-data nibble, and a read-data nibble with its own output-enable. A data-changed flag is set whenever the chain advances. While the flag is set, a read returns 1111 in place of the register contents, so the host knows the value moved during its access sequence. Any completed read clears the flag.

Top module: `bcd_calendar_regs`

## Requirements
- R1: Addresses 4..12 are read/write: 4 minute units, 5 minute tens, 6 hour units, 7 hour tens, 8 day units, 9 day tens, 10 day of week, 11 month units, 12 month tens. A value written to one of these reads back unchanged, within its field width.
- R2: Addresses 1 (tenths), 2 (second units) and 3 (second tens) are read-only, and a write to them changes nothing. Addresses 13 (year phase) and 14 (run latch) are write-only and read back as 0000.
- R3: Bits a field does not use are dropped on write and read back as 0. Second tens, minute tens and day of week use bits 2:0. Hour tens and day tens use bits 1:0. Month tens uses bit 0 only.
- R4: On each advance while running, tenths count 0..9, second units count 0..9 and second tens count 0..5, each carrying into the next field. The carry out of second tens advances the minutes. Minute units count 0..9 and minute tens count 0..5.
- R5: Hours count in 24-hour form. An advance at 23:59:59.9 gives 00:00:00.0 and moves the day on. Day of week counts 1..7 and wraps from 7 to 1 at each day change.
- R6: At a day change, the day after the last day of the month is day 01 of the next month. Months 04, 06, 09 and 11 have 30 days. Months 01, 03, 05, 07, 08, 10 and 12 have 31 days. Month 12 is followed by month 01.
- R7: February has 29 days when the year phase is 1000 (leap year). It has 28 days for any other phase value.
- R8: The year phase register is one-hot and is loaded by a write to address 13. At the change from December 31 to January 1 it steps 1000 -> 0100 -> 0010 -> 0001 -> 1000.
- R9: Writing bit 0 = 1 at address 14 runs the clock, and writing 0 stops it. While stopped, advance pulses are ignored and the three seconds registers are held at 0. After a start, the first advance gives 0.1 s.
- R10: Each advance while running sets the data-changed flag. While the flag is set, a read returns 1111. The end of any read strobe with chip select low clears the flag.
- R11: Read data is driven, with rdata_oe high, only while cs_n and rd_n are both low. Otherwise rdata_oe is low and rdata is 0000.
- R12: A write takes effect on the rising edge of wr_n, and only when cs_n is low at that edge. A strobe with cs_n high changes nothing.
- R13: After reset the clock is stopped, the time is 00:00:00.0, the date is day 01 of month 01, the day of week is 1, the year phase is 1000 and the data-changed flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 10 Hz advance pulse from the prescaler |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; data is loaded on its rising edge |
| addr | input | 4 | Register address |
| wdata | input | 4 | Write data nibble |
| rdata | output | 4 | Read data nibble |
| rdata_oe | output | 1 | High while rdata should drive the shared bus |

## Verification
On every cycle the assertions check the following. The seconds registers stay within their BCD ranges. The seconds stay at zero whenever the run latch is clear. A write to a read-only seconds address leaves the seconds untouched. Every running advance sets the data-changed flag, and a completed read with no advance clears it. The following can only be shown by the bench scenarios, which run whole simulated minutes across day, month and year boundaries: month lengths, the leap-year choice for February, the year-phase rotation (seen indirectly through later Februaries), field masking on read-back, and the 1111 substitution at the port.

// File: rtl/bcd_cal_pkg.sv
`timescale 1ns/1ps
package bcd_cal_pkg;

    localparam int NIB_W  = 4;
    localparam int ADDR_W = 4;
    localparam int DNUM_W = 7;

    typedef enum logic [ADDR_W-1:0] {
        RA_TEST  = 4'd0,  RA_SEC_T = 4'd1,  RA_SEC_U = 4'd2,  RA_SEC_X = 4'd3,
        RA_MIN_U = 4'd4,  RA_MIN_X = 4'd5,  RA_HR_U  = 4'd6,  RA_HR_X  = 4'd7,
        RA_DAY_U = 4'd8,  RA_DAY_X = 4'd9,  RA_WDAY  = 4'd10, RA_MON_U = 4'd11,
        RA_MON_X = 4'd12, RA_YEAR  = 4'd13, RA_RUN   = 4'd14, RA_IRQ   = 4'd15
    } reg_addr_e;

    typedef logic [NIB_W-1:0] nib_t;

    typedef struct packed {
        nib_t s_tenth;
        nib_t s_unit;
        nib_t s_ten;
        nib_t m_unit;
        nib_t m_ten;
        nib_t h_unit;
        nib_t h_ten;
        nib_t d_unit;
        nib_t d_ten;
        nib_t wday;
        nib_t mo_unit;
        nib_t mo_ten;
        nib_t yphase;
    } tod_s;

    localparam nib_t YPHASE_LEAP = 4'b1000;

    function automatic nib_t field_mask(logic [ADDR_W-1:0] a);
        case (reg_addr_e'(a))
            RA_SEC_X, RA_MIN_X, RA_WDAY: return 4'b0111;
            RA_HR_X, RA_DAY_X:           return 4'b0011;
            RA_MON_X:                    return 4'b0001;
            default:                     return 4'b1111;
        endcase
    endfunction

    // {carry, next}: wraps to base once v reaches top
    function automatic logic [NIB_W:0] bcd_step(nib_t v, nib_t top, nib_t base);
        if (v >= top) return {1'b1, base};
        return {1'b0, v + 4'd1};
    endfunction

    function automatic logic [DNUM_W-1:0] month_len(nib_t mt, nib_t mu, logic leap);
        logic [DNUM_W-1:0] num;
        num = (mt[0] ? DNUM_W'(10) : DNUM_W'(0)) + DNUM_W'(mu);
        case (num)
            DNUM_W'(2):                                       return leap ? DNUM_W'(29) : DNUM_W'(28);
            DNUM_W'(4), DNUM_W'(6), DNUM_W'(9), DNUM_W'(11): return DNUM_W'(30);
            default:                                          return DNUM_W'(31);
        endcase
    endfunction

endpackage

// File: rtl/bcd_cal_host.sv
`timescale 1ns/1ps
module bcd_cal_host
    import bcd_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              wr_en,
    output logic              rd_done,
    output logic              rd_on
);
    logic wr_q, rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= wr_n;
            rd_q <= rd_n;
        end
    end

    assign wr_en   = !wr_q && wr_n && !cs_n;
    assign rd_done = !rd_q && rd_n && !cs_n;
    assign rd_on   = !cs_n && !rd_n;

endmodule

// File: rtl/bcd_cal_chain.sv
`timescale 1ns/1ps
module bcd_cal_chain
    import bcd_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NIB_W-1:0]  wr_data,
    output tod_s              tod,
    output logic              run
);
    tod_s               nx;
    logic               run_nx;
    logic               cy;
    logic [NIB_W:0]     st;
    logic [DNUM_W-1:0]  dnum;
    logic [NIB_W-1:0]   wm;

    always_comb begin
        nx     = tod;
        run_nx = run;
        cy     = run && adv;
        st     = '0;
        dnum   = '0;
        wm     = wr_data & field_mask(wr_addr);
        // seconds and minutes
        if (cy) begin st = bcd_step(tod.s_tenth, 4'd9, 4'd0); nx.s_tenth = st[3:0]; cy = st[4]; end
        if (cy) begin st = bcd_step(tod.s_unit,  4'd9, 4'd0); nx.s_unit  = st[3:0]; cy = st[4]; end
        if (cy) begin st = bcd_step(tod.s_ten,   4'd5, 4'd0); nx.s_ten   = st[3:0]; cy = st[4]; end
        if (cy) begin st = bcd_step(tod.m_unit,  4'd9, 4'd0); nx.m_unit  = st[3:0]; cy = st[4]; end
        if (cy) begin st = bcd_step(tod.m_ten,   4'd5, 4'd0); nx.m_ten   = st[3:0]; cy = st[4]; end
        // hours, 24-hour form
        if (cy) begin
            if (tod.h_ten >= 4'd2 && tod.h_unit >= 4'd3) begin
                nx.h_ten  = 4'd0;
                nx.h_unit = 4'd0;
            end else begin
                st = bcd_step(tod.h_unit, 4'd9, 4'd0);
                nx.h_unit = st[3:0];
                if (st[4]) nx.h_ten = tod.h_ten + 4'd1;
                cy = 1'b0;
            end
        end
        // day of week and day of month
        if (cy) begin
            nx.wday = (tod.wday >= 4'd7) ? 4'd1 : tod.wday + 4'd1;
            dnum = DNUM_W'(tod.d_ten) * DNUM_W'(10) + DNUM_W'(tod.d_unit);
            if (dnum >= month_len(tod.mo_ten, tod.mo_unit, tod.yphase == YPHASE_LEAP)) begin
                nx.d_ten  = 4'd0;
                nx.d_unit = 4'd1;
            end else begin
                st = bcd_step(tod.d_unit, 4'd9, 4'd0);
                nx.d_unit = st[3:0];
                if (st[4]) nx.d_ten = tod.d_ten + 4'd1;
                cy = 1'b0;
            end
        end
        // month
        if (cy) begin
            if (tod.mo_ten[0] && tod.mo_unit >= 4'd2) begin
                nx.mo_ten  = 4'd0;
                nx.mo_unit = 4'd1;
            end else begin
                st = bcd_step(tod.mo_unit, 4'd9, 4'd0);
                nx.mo_unit = st[3:0];
                if (st[4]) nx.mo_ten = 4'd1;
                cy = 1'b0;
            end
        end
        // year phase rotates one place toward the leap year
        if (cy) nx.yphase = {tod.yphase[0], tod.yphase[3:1]};
        // host load has priority over the advance for the written field
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_MIN_U: nx.m_unit  = wm;
                RA_MIN_X: nx.m_ten   = wm;
                RA_HR_U:  nx.h_unit  = wm;
                RA_HR_X:  nx.h_ten   = wm;
                RA_DAY_U: nx.d_unit  = wm;
                RA_DAY_X: nx.d_ten   = wm;
                RA_WDAY:  nx.wday    = wm;
                RA_MON_U: nx.mo_unit = wm;
                RA_MON_X: nx.mo_ten  = wm;
                RA_YEAR:  nx.yphase  = wr_data;
                RA_RUN:   run_nx     = wr_data[0];
                default:  ;
            endcase
        end
        if (!run_nx) begin
            nx.s_tenth = 4'd0;
            nx.s_unit  = 4'd0;
            nx.s_ten   = 4'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tod     <= '{s_tenth: 4'd0, s_unit: 4'd0, s_ten: 4'd0, m_unit: 4'd0, m_ten: 4'd0,
                         h_unit: 4'd0, h_ten: 4'd0, d_unit: 4'd1, d_ten: 4'd0, wday: 4'd1,
                         mo_unit: 4'd1, mo_ten: 4'd0, yphase: YPHASE_LEAP};
            run     <= 1'b0;
        end else begin
            tod     <= nx;
            run     <= run_nx;
        end
    end

    assert_sec_range_R4: assert property (@(posedge clk) disable iff (rst)
        tod.s_tenth <= 4'd9 && tod.s_unit <= 4'd9 && tod.s_ten <= 4'd5);

    assert_stop_holds_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !run |=> (tod.s_tenth == 4'd0 && tod.s_unit == 4'd0 && tod.s_ten == 4'd0));

    assert_sec_readonly_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= 4'd1 && wr_addr <= 4'd3 && !(run && adv))
        |=> $stable({tod.s_tenth, tod.s_unit, tod.s_ten}));

endmodule

// File: rtl/bcd_cal_readout.sv
`timescale 1ns/1ps
module bcd_cal_readout
    import bcd_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_live,
    input  logic              rd_done,
    input  logic              rd_on,
    input  logic [ADDR_W-1:0] addr,
    input  tod_s              tod,
    output logic [NIB_W-1:0]  rdata,
    output logic              rdata_oe
);
    logic       changed;
    nib_t       sel;

    always_ff @(posedge clk) begin
        if (rst)           changed <= 1'b0;
        else if (adv_live) changed <= 1'b1;
        else if (rd_done)  changed <= 1'b0;
    end

    always_comb begin
        case (reg_addr_e'(addr))
            RA_SEC_T: sel = tod.s_tenth;
            RA_SEC_U: sel = tod.s_unit;
            RA_SEC_X: sel = tod.s_ten;
            RA_MIN_U: sel = tod.m_unit;
            RA_MIN_X: sel = tod.m_ten;
            RA_HR_U:  sel = tod.h_unit;
            RA_HR_X:  sel = tod.h_ten;
            RA_DAY_U: sel = tod.d_unit;
            RA_DAY_X: sel = tod.d_ten;
            RA_WDAY:  sel = tod.wday;
            RA_MON_U: sel = tod.mo_unit;
            RA_MON_X: sel = tod.mo_ten;
            default:  sel = 4'd0;
        endcase
    end

    assign rdata_oe = rd_on;
    assign rdata    = !rd_on ? 4'd0 : changed ? 4'b1111 : (sel & field_mask(addr));

    assert_flag_set_R10: assert property (@(posedge clk) disable iff (rst)
        adv_live |=> changed);

    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_done && !adv_live) |=> !changed);

endmodule

// File: rtl/bcd_calendar_regs.sv
`timescale 1ns/1ps
module bcd_calendar_regs
    import bcd_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NIB_W-1:0]  wdata,
    output logic [NIB_W-1:0]  rdata,
    output logic              rdata_oe
);
    logic wr_en, rd_done, rd_on, run;
    tod_s tod;

    bcd_cal_host u_host (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .wr_en(wr_en), .rd_done(rd_done), .rd_on(rd_on)
    );

    bcd_cal_chain u_chain (
        .clk(clk), .rst(rst), .adv(tick), .wr_en(wr_en), .wr_addr(addr),
        .wr_data(wdata), .tod(tod), .run(run)
    );

    bcd_cal_readout u_rd (
        .clk(clk), .rst(rst), .adv_live(run && tick), .rd_done(rd_done),
        .rd_on(rd_on), .addr(addr), .tod(tod), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    assert_bus_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (!rdata_oe && rdata == 4'd0));

endmodule

// File: tb/sim_bcd_calendar_regs.sv
`timescale 1ns/1ps
module sim_bcd_calendar_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [3:0] addr = 4'd0, wdata = 4'd0;
    logic [3:0] rdata;
    logic       rdata_oe;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bcd_calendar_regs u0 (
        .clk(clk), .rst(rst), .tick(tick), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d, input logic sel_n = 1'b0);
        @(negedge clk); addr = a; wdata = d; cs_n = sel_n; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [3:0] v);
        @(negedge clk); addr = a; cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk); v = rdata;
        rd_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic flush();
        logic [3:0] v;
        rd(4'd1, v);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [3:0] v;
        rd(4'd4, v);  chk("R13 minute units", v, 4'd0);
        rd(4'd7, v);  chk("R13 hour tens", v, 4'd0);
        rd(4'd8, v);  chk("R13 day units", v, 4'd1);
        rd(4'd11, v); chk("R13 month units", v, 4'd1);
        rd(4'd10, v); chk("R13 weekday", v, 4'd1);
        ticks(3);
        rd(4'd1, v);  chk("R13 stopped tenths after ticks", v, 4'd0);
        rd(4'd13, v); chk("R2 year phase reads 0", v, 4'd0);
        rd(4'd14, v); chk("R2 run latch reads 0", v, 4'd0);
    endtask

    task automatic t_access();
        logic [3:0] v;
        wr(4'd4, 4'd7);  rd(4'd4, v);  chk("R1 minute units rw", v, 4'd7);
        wr(4'd6, 4'd9);  rd(4'd6, v);  chk("R1 hour units rw", v, 4'd9);
        wr(4'd11, 4'd8); rd(4'd11, v); chk("R1 month units rw", v, 4'd8);
        wr(4'd5, 4'hF);  rd(4'd5, v);  chk("R3 minute tens mask", v, 4'd7);
        wr(4'd7, 4'hF);  rd(4'd7, v);  chk("R3 hour tens mask", v, 4'd3);
        wr(4'd10, 4'hF); rd(4'd10, v); chk("R3 weekday mask", v, 4'd7);
        wr(4'd12, 4'hF); rd(4'd12, v); chk("R3 month tens mask", v, 4'd1);
        wr(4'd9, 4'hE);  rd(4'd9, v);  chk("R3 day tens mask", v, 4'd2);
        wr(4'd4, 4'd3, 1'b1); rd(4'd4, v); chk("R12 write with cs_n high ignored", v, 4'd7);
        wr(4'd1, 4'd5); rd(4'd1, v); chk("R2 tenths write ignored", v, 4'd0);
        wr(4'd3, 4'd4); rd(4'd3, v); chk("R2 second tens write ignored", v, 4'd0);
    endtask

    task automatic t_bus();
        @(negedge clk); addr = 4'd4; cs_n = 1'b0; rd_n = 1'b1;
        @(negedge clk); chk("R11 oe low without read strobe", {3'b0, rdata_oe}, 4'd0);
        cs_n = 1'b1; rd_n = 1'b0;
        @(negedge clk); chk("R11 oe low without chip select", {3'b0, rdata_oe}, 4'd0);
        chk("R11 rdata idle zero", rdata, 4'd0);
        cs_n = 1'b0;
        @(negedge clk); chk("R11 oe high on select and read", {3'b0, rdata_oe}, 4'd1);
        rd_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic t_run_flag();
        logic [3:0] v;
        wr(4'd4, 4'd0); wr(4'd5, 4'd0); wr(4'd14, 4'd1);
        ticks(1);
        rd(4'd4, v); chk("R10 read during change gives 1111", v, 4'hF);
        rd(4'd1, v); chk("R9 first tenth after start", v, 4'd1);
        rd(4'd4, v); chk("R10 flag cleared by read", v, 4'd0);
        ticks(24);
        flush();
        rd(4'd1, v); chk("R4 tenths at 2.5 s", v, 4'd5);
        rd(4'd2, v); chk("R4 second units at 2.5 s", v, 4'd2);
        wr(4'd14, 4'd0);
        rd(4'd2, v); chk("R9 seconds cleared by stop", v, 4'd0);
        ticks(4);
        rd(4'd1, v); chk("R9 stopped: no flag, tenths held", v, 4'd0);
        wr(4'd14, 4'd1);
        ticks(600);
        flush();
        rd(4'd4, v); chk("R4 minute carry after 60 s", v, 4'd1);
        rd(4'd3, v); chk("R4 second tens wrap", v, 4'd0);
        wr(4'd14, 4'd0);
    endtask

    // Set 23:59 on the given date, run one minute, check the new date
    task automatic roll(input string tag, input logic [3:0] mx, input logic [3:0] mu,
                        input logic [3:0] dx, input logic [3:0] du, input logic [3:0] wd,
                        input logic set_y, input logic [3:0] yv,
                        input logic [3:0] edx, input logic [3:0] edu,
                        input logic [3:0] emx, input logic [3:0] emu, input logic [3:0] ewd);
        logic [3:0] v;
        wr(4'd14, 4'd0);
        wr(4'd4, 4'd9); wr(4'd5, 4'd5); wr(4'd6, 4'd3); wr(4'd7, 4'd2);
        wr(4'd12, mx); wr(4'd11, mu); wr(4'd9, dx); wr(4'd8, du); wr(4'd10, wd);
        if (set_y) wr(4'd13, yv);
        wr(4'd14, 4'd1);
        ticks(600);
        wr(4'd14, 4'd0);
        flush();
        rd(4'd9, v);  chk({tag, " day tens"}, v, edx);
        rd(4'd8, v);  chk({tag, " day units"}, v, edu);
        rd(4'd12, v); chk({tag, " month tens"}, v, emx);
        rd(4'd11, v); chk({tag, " month units"}, v, emu);
        rd(4'd10, v); chk({tag, " weekday"}, v, ewd);
        rd(4'd7, v);  chk({tag, " hour tens"}, v, 4'd0);
        rd(4'd6, v);  chk({tag, " hour units"}, v, 4'd0);
        rd(4'd5, v);  chk({tag, " minute tens"}, v, 4'd0);
    endtask

    initial begin : wd
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_access();
        t_bus();
        t_run_flag();
        roll("R5 day units step and weekday wrap", 0, 1, 0, 9, 7, 0, 0, 1, 0, 0, 1, 1);
        roll("R6 31-day January", 0, 1, 3, 0, 2, 0, 0, 3, 1, 0, 1, 3);
        roll("R6 January to February", 0, 1, 3, 1, 3, 0, 0, 0, 1, 0, 2, 4);
        roll("R6 30-day April", 0, 4, 3, 0, 4, 0, 0, 0, 1, 0, 5, 5);
        roll("R6 November to December", 1, 1, 3, 0, 5, 0, 0, 0, 1, 1, 2, 6);
        roll("R7 leap February 28", 0, 2, 2, 8, 6, 1, 4'b1000, 2, 9, 0, 2, 7);
        roll("R7 leap February 29", 0, 2, 2, 9, 7, 0, 0, 0, 1, 0, 3, 1);
        roll("R7 non-leap February 28", 0, 2, 2, 8, 1, 1, 4'b0010, 0, 1, 0, 3, 2);
        roll("R8 December 31 to January", 1, 2, 3, 1, 2, 1, 4'b1000, 0, 1, 0, 1, 3);
        roll("R8 phase left leap year", 0, 2, 2, 8, 3, 0, 0, 0, 1, 0, 3, 4);
        roll("R8 year before leap at new year", 1, 2, 3, 1, 4, 1, 4'b0001, 0, 1, 0, 1, 5);
        roll("R8 phase wrapped to leap year", 0, 2, 2, 8, 5, 0, 0, 2, 9, 0, 2, 6);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule